// File: doc/BRIEF.md
# KCS Channel Register Bank

This block is the management-controller side of three Keyboard Controller Style (KCS) mailbox channels. The local processor reaches each channel through a byte-wide memory-mapped bus. Each channel holds a status byte, an input buffer that the external host fills, an output buffer that the local processor loads, a control byte, and two host interrupt bytes. On a separate host port, an external agent picks a channel, writes a data or command byte, and reads back the output byte.

The status byte follows the usual KCS meaning. It carries two state bits, a command/data flag, an attention bit and the two buffer-full flags. All three channels drive one shared interrupt line toward the local processor. A channel raises the line when the host fills its input buffer or empties its output buffer, and lowers it when the local processor services that buffer. Each of the two sides has its own enable bit in the channel's control byte.

Top module: `kcs_bank`

## Requirements
- R1: Channel k begins at bus offset 0x0C + 0x12*k (k = 0..2), and registers inside a channel are 2 bytes apart. The register index order is: status, data-out, data-in, data-out-SCI, data-out-SMI, data-in-SCI, control, host interrupt control, host interrupt enable. A bus access to an odd offset, or to an offset below 0x0C or at/above 0x42, returns 0 and changes nothing.
- R2: After reset every channel reads status 0x00, control 0xC0, host interrupt control 0x41 and host interrupt enable 0x00. All flags are clear and the interrupt output is low.
- R3: Status layout: bits 7:6 state, bit 3 CMD, bit 2 attention, bit 1 IBF, bit 0 OBF. A bus write to status sets bits 7:4 and bit 2 to the written value and leaves bits 3, 1 and 0 unchanged.
- R4: A host write to channel k stores the byte in the input buffer and sets IBF. CMD becomes 1 for a command byte and 0 for a data byte. A host channel number of 3 selects no channel.
- R5: A bus read of data-in or data-in-SCI returns the input buffer in the same cycle and clears IBF.
- R6: A bus write to data-out, data-out-SCI or data-out-SMI loads the output buffer and sets OBF. The host read port shows the selected channel's output buffer, and a host read clears that channel's OBF.
- R7: With control bit 0 set, a host write raises the channel's interrupt and a bus read of data-in lowers it.
- R8: With control bit 1 set, a host read raises the channel's interrupt and a bus write of data-out lowers it.
- R9: A bus read of any data-out register returns 0. A bus write to a data-in register leaves the input buffer and IBF unchanged.
- R10: The interrupt output is the OR of the three channels. If a channel's enable bit for a side is clear, events on that side leave the output unchanged.
- R11: If a host write and a bus data-in read hit the same channel in the same cycle, the read returns the old byte, and IBF and the interrupt end up set. If a bus data-out write and a host read hit the same channel in the same cycle, the host sees the old byte, OBF ends up set, and the interrupt is lowered unless the input side raises it in that cycle.
- R12: The control, host interrupt control and host interrupt enable registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access strobe, one cycle per access |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 8 | Byte offset in the bank |
| busWdata | input | 8 | Bus write data |
| busRdata | output | 8 | Bus read data, valid in the access cycle |
| hostChan | input | 2 | Channel selected by the host port |
| hostWrite | input | 1 | Host writes hostWdata into the selected channel |
| hostIsCmd | input | 1 | Marks the host write as a command byte |
| hostWdata | input | 8 | Host write data |
| hostRead | input | 1 | Host consumes the selected output buffer |
| hostRdata | output | 8 | Output buffer of the selected channel |
| ibfFlags | output | 3 | IBF of each channel |
| obfFlags | output | 3 | OBF of each channel |
| cmdFlags | output | 3 | CMD of each channel |
| irq | output | 1 | Shared interrupt toward the local processor |

## Verification
Two kinds of access can reach the same buffer flag in one cycle. The first is a host write to a channel while the local processor reads that channel's input buffer. The second is a host read while the processor loads that channel's output buffer. The bench drives both pairs in a single cycle with both interrupt enables set. It then checks the byte returned by the colliding read, the flag state one cycle later, and the interrupt level. A follow-up read confirms that the newer byte was not lost.

// File: rtl/kcs_bank_pkg.sv
package kcs_bank_pkg;

  // Register index inside one channel; the order is fixed by the address map.
  typedef enum logic [3:0] {
    RS_STATUS  = 4'd0,
    RS_OUT     = 4'd1,
    RS_IN      = 4'd2,
    RS_OUT_SCI = 4'd3,
    RS_OUT_SMI = 4'd4,
    RS_IN_SCI  = 4'd5,
    RS_CTRL    = 4'd6,
    RS_HIC     = 4'd7,
    RS_HIE     = 4'd8
  } regSel_t;

  // Per-channel strobes from decode to the storage.
  typedef struct packed {
    logic coreRdIn;
    logic coreWrOut;
    logic coreWrStat;
    logic coreWrCtl;
    logic coreWrHic;
    logic coreWrHie;
    logic hostWr;
    logic hostRd;
  } chanStrobe_t;

  localparam logic [7:0] STAT_SW_MASK = 8'hF4;
  localparam logic [7:0] CTRL_RST     = 8'hC0;
  localparam logic [7:0] HIC_RST      = 8'h41;
  localparam logic [7:0] HIE_RST      = 8'h00;

endpackage

// File: rtl/kcs_bank_ctrl.sv
module kcs_bank_ctrl
  import kcs_bank_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_CHANS  = 3,
  parameter int BASE0      = 12,
  parameter int REG_STRIDE = 2,
  parameter int REGS_PER   = 9,
  parameter int CW         = 2
) (
  input  logic                          busValid,
  input  logic                          busWrite,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [CW-1:0]                 hostChan,
  input  logic                          hostWrite,
  input  logic                          hostRead,
  output chanStrobe_t [NUM_CHANS-1:0]   strobes,
  output logic                          rdHit,
  output logic [CW-1:0]                 rdChan,
  output regSel_t                       rdReg
);

  localparam int CHAN_SPAN = REG_STRIDE * REGS_PER;
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE0);
  localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(BASE0 + NUM_CHANS * CHAN_SPAN);
  localparam logic [ADDR_W-1:0] SPAN_A  = ADDR_W'(CHAN_SPAN);
  localparam logic [ADDR_W-1:0] STEP_A  = ADDR_W'(REG_STRIDE);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] chanRaw;
  logic [ADDR_W-1:0] inChan;
  logic [ADDR_W-1:0] regRaw;
  logic              addrOk;
  regSel_t           regSel;

  assign offset  = busAddr - BASE_A;
  assign chanRaw = offset / SPAN_A;
  assign inChan  = offset % SPAN_A;
  assign regRaw  = inChan / STEP_A;
  assign addrOk  = (busAddr >= BASE_A) && (busAddr < LIMIT_A) && ((inChan % STEP_A) == '0);
  assign regSel  = regSel_t'(regRaw[3:0]);

  assign rdHit  = busValid && !busWrite && addrOk;
  assign rdChan = CW'(chanRaw);
  assign rdReg  = regSel;

  always_comb begin
    for (int k = 0; k < NUM_CHANS; k++) begin
      strobes[k] = '0;
      if (busValid && addrOk && (chanRaw == ADDR_W'(k))) begin
        if (busWrite) begin
          case (regSel)
            RS_STATUS:                      strobes[k].coreWrStat = 1'b1;
            RS_OUT, RS_OUT_SCI, RS_OUT_SMI: strobes[k].coreWrOut  = 1'b1;
            RS_CTRL:                        strobes[k].coreWrCtl  = 1'b1;
            RS_HIC:                         strobes[k].coreWrHic  = 1'b1;
            RS_HIE:                         strobes[k].coreWrHie  = 1'b1;
            default: ;
          endcase
        end else begin
          case (regSel)
            RS_IN, RS_IN_SCI: strobes[k].coreRdIn = 1'b1;
            default: ;
          endcase
        end
      end
      strobes[k].hostWr = hostWrite && (hostChan == CW'(k));
      strobes[k].hostRd = hostRead  && (hostChan == CW'(k));
    end
  end

endmodule

// File: rtl/kcs_bank_datapath.sv
module kcs_bank_datapath
  import kcs_bank_pkg::*;
#(
  parameter int NUM_CHANS = 3,
  parameter int CW        = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  chanStrobe_t [NUM_CHANS-1:0] strobes,
  input  logic                        rdHit,
  input  logic [CW-1:0]               rdChan,
  input  regSel_t                     rdReg,
  input  logic [7:0]                  busWdata,
  input  logic [7:0]                  hostWdata,
  input  logic                        hostIsCmd,
  input  logic [CW-1:0]               hostChan,
  output logic [7:0]                  busRdata,
  output logic [7:0]                  hostRdata,
  output logic [NUM_CHANS-1:0]        ibfFlags,
  output logic [NUM_CHANS-1:0]        obfFlags,
  output logic [NUM_CHANS-1:0]        cmdFlags,
  output logic [NUM_CHANS-1:0]        irqFlags
);

  logic [NUM_CHANS-1:0][7:0] statusAll;
  logic [NUM_CHANS-1:0][7:0] dinAll;
  logic [NUM_CHANS-1:0][7:0] doutAll;
  logic [NUM_CHANS-1:0][7:0] ctlAll;
  logic [NUM_CHANS-1:0][7:0] hicAll;
  logic [NUM_CHANS-1:0][7:0] hieAll;

  for (genvar k = 0; k < NUM_CHANS; k++) begin : gChan
    chanStrobe_t s;
    logic [7:0] swBits, din, dout, ctl, hic, hie;
    logic ibf, obf, cmd, irqState, irqNext;
    logic inRaise, inLower, outRaise, outLower;

    assign s = strobes[k];

    // Input side: host fill beats local drain; output side: local load beats host drain.
    assign inRaise  = s.hostWr & ctl[0];
    assign inLower  = s.coreRdIn & ctl[0] & ~s.hostWr;
    assign outRaise = s.hostRd & ctl[1] & ~s.coreWrOut;
    assign outLower = s.coreWrOut & ctl[1];
    assign irqNext  = (inRaise | outRaise) ? 1'b1 :
                      (inLower | outLower) ? 1'b0 : irqState;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        swBits   <= '0;
        din      <= '0;
        dout     <= '0;
        ctl      <= CTRL_RST;
        hic      <= HIC_RST;
        hie      <= HIE_RST;
        ibf      <= 1'b0;
        obf      <= 1'b0;
        cmd      <= 1'b0;
        irqState <= 1'b0;
      end else begin
        if (s.coreWrStat) swBits <= busWdata & STAT_SW_MASK;
        if (s.coreWrCtl)  ctl <= busWdata;
        if (s.coreWrHic)  hic <= busWdata;
        if (s.coreWrHie)  hie <= busWdata;
        if (s.hostWr) begin
          din <= hostWdata;
          ibf <= 1'b1;
          cmd <= hostIsCmd;
        end else if (s.coreRdIn) begin
          ibf <= 1'b0;
        end
        if (s.coreWrOut) begin
          dout <= busWdata;
          obf  <= 1'b1;
        end else if (s.hostRd) begin
          obf <= 1'b0;
        end
        irqState <= irqNext;
      end
    end

    assign statusAll[k] = {swBits[7:4], cmd, swBits[2], ibf, obf};
    assign dinAll[k]    = din;
    assign doutAll[k]   = dout;
    assign ctlAll[k]    = ctl;
    assign hicAll[k]    = hic;
    assign hieAll[k]    = hie;
    assign ibfFlags[k]  = ibf;
    assign obfFlags[k]  = obf;
    assign cmdFlags[k]  = cmd;
    assign irqFlags[k]  = irqState;
  end

  always_comb begin
    busRdata = '0;
    if (rdHit && (int'(rdChan) < NUM_CHANS)) begin
      case (rdReg)
        RS_STATUS:        busRdata = statusAll[rdChan];
        RS_IN, RS_IN_SCI: busRdata = dinAll[rdChan];
        RS_CTRL:          busRdata = ctlAll[rdChan];
        RS_HIC:           busRdata = hicAll[rdChan];
        RS_HIE:           busRdata = hieAll[rdChan];
        default:          busRdata = '0;
      endcase
    end
  end

  assign hostRdata = (int'(hostChan) < NUM_CHANS) ? doutAll[hostChan] : '0;

endmodule

// File: rtl/kcs_bank.sv
module kcs_bank
  import kcs_bank_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_CHANS  = 3,
  parameter int BASE0      = 12,
  parameter int REG_STRIDE = 2,
  parameter int REGS_PER   = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [7:0]           busWdata,
  output logic [7:0]           busRdata,
  input  logic [1:0]           hostChan,
  input  logic                 hostWrite,
  input  logic                 hostIsCmd,
  input  logic [7:0]           hostWdata,
  input  logic                 hostRead,
  output logic [7:0]           hostRdata,
  output logic [NUM_CHANS-1:0] ibfFlags,
  output logic [NUM_CHANS-1:0] obfFlags,
  output logic [NUM_CHANS-1:0] cmdFlags,
  output logic                 irq
);

  localparam int CW = 2;

  chanStrobe_t [NUM_CHANS-1:0] strobes;
  logic                        rdHit;
  logic [CW-1:0]               rdChan;
  regSel_t                     rdReg;
  logic [NUM_CHANS-1:0]        irqFlags;

  kcs_bank_ctrl #(
    .ADDR_W(ADDR_W), .NUM_CHANS(NUM_CHANS), .BASE0(BASE0),
    .REG_STRIDE(REG_STRIDE), .REGS_PER(REGS_PER), .CW(CW)
  ) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .hostChan(hostChan), .hostWrite(hostWrite), .hostRead(hostRead),
    .strobes(strobes), .rdHit(rdHit), .rdChan(rdChan), .rdReg(rdReg)
  );

  kcs_bank_datapath #(.NUM_CHANS(NUM_CHANS), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rdHit(rdHit), .rdChan(rdChan), .rdReg(rdReg),
    .busWdata(busWdata), .hostWdata(hostWdata), .hostIsCmd(hostIsCmd),
    .hostChan(hostChan), .busRdata(busRdata), .hostRdata(hostRdata),
    .ibfFlags(ibfFlags), .obfFlags(obfFlags), .cmdFlags(cmdFlags),
    .irqFlags(irqFlags)
  );

  assign irq = |irqFlags;

endmodule

// File: rtl/kcs_bank_chk.sv
module kcs_bank_chk #(
  parameter int NUM_CHANS = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busValid,
  input logic                 busWrite,
  input logic [7:0]           busAddr,
  input logic [7:0]           busRdata,
  input logic [1:0]           hostChan,
  input logic                 hostWrite,
  input logic                 hostIsCmd,
  input logic                 hostRead,
  input logic [NUM_CHANS-1:0] ibfFlags,
  input logic [NUM_CHANS-1:0] obfFlags,
  input logic [NUM_CHANS-1:0] cmdFlags,
  input logic                 irq
);

  for (genvar k = 0; k < NUM_CHANS; k++) begin : gFlag
    assert_host_fill_R4: assert property (@(posedge clk) disable iff (!rstN)
      (hostWrite && hostChan == 2'(k)) |=> (ibfFlags[k] && cmdFlags[k] == $past(hostIsCmd)));

    assert_ibf_source_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ibfFlags[k]) |-> $past(hostWrite && hostChan == 2'(k)));

    assert_ibf_drain_R5: assert property (@(posedge clk) disable iff (!rstN)
      $fell(ibfFlags[k]) |-> $past(busValid && !busWrite));

    assert_obf_drain_R6: assert property (@(posedge clk) disable iff (!rstN)
      $fell(obfFlags[k]) |-> $past(hostRead && hostChan == 2'(k)));
  end

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(hostWrite || hostRead));

  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(busValid));

  assert_odd_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr[0]) |-> (busRdata == 8'h00));

endmodule

bind kcs_bank kcs_bank_chk #(.NUM_CHANS(NUM_CHANS)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busRdata(busRdata), .hostChan(hostChan),
  .hostWrite(hostWrite), .hostIsCmd(hostIsCmd), .hostRead(hostRead),
  .ibfFlags(ibfFlags), .obfFlags(obfFlags), .cmdFlags(cmdFlags), .irq(irq)
);

// File: tb/kcs_bank_tb.sv
module kcs_bank_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busValid = 1'b0, busWrite = 1'b0;
  logic [7:0] busAddr = '0, busWdata = '0, busRdata;
  logic [1:0] hostChan = '0;
  logic       hostWrite = 1'b0, hostIsCmd = 1'b0, hostRead = 1'b0;
  logic [7:0] hostWdata = '0, hostRdata;
  logic [2:0] ibfFlags, obfFlags, cmdFlags;
  logic       irq;

  always #2 clk = ~clk;

  kcs_bank u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .hostChan(hostChan), .hostWrite(hostWrite), .hostIsCmd(hostIsCmd),
    .hostWdata(hostWdata), .hostRead(hostRead), .hostRdata(hostRdata),
    .ibfFlags(ibfFlags), .obfFlags(obfFlags), .cmdFlags(cmdFlags), .irq(irq)
  );

  // Sources the monitor can compare.
  localparam int SRC_BUS = 0, SRC_HOST = 1, SRC_IRQ = 2, SRC_IBF = 3, SRC_OBF = 4, SRC_CMD = 5;

  typedef struct {
    int         src;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t expQ[$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;

  function automatic logic [7:0] observe(int src);
    case (src)
      SRC_BUS:  return busRdata;
      SRC_HOST: return hostRdata;
      SRC_IRQ:  return {7'd0, irq};
      SRC_IBF:  return {5'd0, ibfFlags};
      SRC_OBF:  return {5'd0, obfFlags};
      default:  return {5'd0, cmdFlags};
    endcase
  endfunction

  // Monitor: samples 1 ns after inputs change, 1 ns before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it  = expQ.pop_front();
        got = observe(it.src);
        nChecks++;
        if (got !== it.exp) begin
          nFails++;
          $display("FAIL %s: got 0x%02h expected 0x%02h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic expect_val(int src, logic [7:0] exp, string tag);
    expQ.push_back('{src, exp, tag});
  endtask

  task automatic quiet();
    busValid = 0; busWrite = 0; hostWrite = 0; hostRead = 0; hostIsCmd = 0;
  endtask

  task automatic idleChk(int src, logic [7:0] exp, string tag);
    @(negedge clk); quiet();
    expect_val(src, exp, tag);
  endtask

  task automatic busWr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); quiet();
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
  endtask

  task automatic busRd(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk); quiet();
    busValid = 1; busWrite = 0; busAddr = a;
    expect_val(SRC_BUS, exp, tag);
  endtask

  task automatic hostWr(logic [1:0] ch, logic [7:0] d, logic isCmd);
    @(negedge clk); quiet();
    hostChan = ch; hostWrite = 1; hostWdata = d; hostIsCmd = isCmd;
  endtask

  task automatic hostRd(logic [1:0] ch, logic [7:0] exp, string tag);
    @(negedge clk); quiet();
    hostChan = ch; hostRead = 1;
    expect_val(SRC_HOST, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 reset state
    idleChk(SRC_IRQ, 8'h00, "R2 irq");
    expect_val(SRC_IBF, 8'h00, "R2 ibf");
    expect_val(SRC_OBF, 8'h00, "R2 obf");
    expect_val(SRC_CMD, 8'h00, "R2 cmd");
    for (int k = 0; k < 3; k++) begin
      logic [7:0] b;
      b = 8'(12 + 18 * k);
      busRd(b,          8'h00, "R2 status");
      busRd(b + 8'h0C,  8'hC0, "R2 control");
      busRd(b + 8'h0E,  8'h41, "R2 host int ctrl");
      busRd(b + 8'h10,  8'h00, "R2 host int enable");
    end

    // R1 out-of-range and misaligned accesses
    busRd(8'h0B, 8'h00, "R1 below base");
    busRd(8'h42, 8'h00, "R1 above limit");
    busRd(8'h0D, 8'h00, "R1 odd offset");
    busWr(8'h19, 8'hFF);
    busWr(8'h42, 8'hFF);
    busRd(8'h18, 8'hC0, "R1 odd write ignored");

    // R12 read-back of control and host interrupt registers
    busWr(8'h18, 8'h00);
    busRd(8'h18, 8'h00, "R12 control ch0");
    busWr(8'h2C, 8'h5A);
    busRd(8'h2C, 8'h5A, "R12 int ctrl ch1");
    busWr(8'h40, 8'h3C);
    busRd(8'h40, 8'h3C, "R12 int enable ch2");

    // R3 status write masking
    busWr(8'h1E, 8'hFF);
    busRd(8'h1E, 8'hF4, "R3 writable bits");
    hostWr(2'd1, 8'h77, 1'b1);
    busRd(8'h1E, 8'hFE, "R3 flags plus written bits");
    busWr(8'h1E, 8'h00);
    busRd(8'h1E, 8'h0A, "R3 flags preserved");
    busRd(8'h28, 8'h77, "R5 data-in-SCI read");
    busRd(8'h1E, 8'h08, "R5 IBF cleared CMD kept");
    idleChk(SRC_CMD, 8'h02, "R4 cmd ch1");

    // R4/R5 data byte on ch2
    hostWr(2'd2, 8'h33, 1'b0);
    idleChk(SRC_IBF, 8'h04, "R4 ibf ch2");
    expect_val(SRC_CMD, 8'h02, "R4 data clears cmd");
    busRd(8'h34, 8'h33, "R5 data-in read");
    idleChk(SRC_IBF, 8'h00, "R5 ibf cleared");
    hostWr(2'd3, 8'hEE, 1'b1);
    idleChk(SRC_IBF, 8'h00, "R4 channel 3 selects nothing");

    // R9 write to data-in ignored
    busWr(8'h22, 8'h99);
    busRd(8'h22, 8'h77, "R9 data-in unchanged");
    idleChk(SRC_IBF, 8'h00, "R9 ibf unchanged");

    // R6 output path on all three data-out aliases
    busWr(8'h0E, 8'hA5);
    idleChk(SRC_OBF, 8'h01, "R6 obf ch0");
    busRd(8'h0E, 8'h00, "R9 data-out reads 0");
    hostRd(2'd0, 8'hA5, "R6 host read ch0");
    idleChk(SRC_OBF, 8'h00, "R6 obf cleared");
    busWr(8'h14, 8'h5C);
    hostRd(2'd0, 8'h5C, "R6 data-out-SMI");
    busWr(8'h24, 8'hC3);
    idleChk(SRC_OBF, 8'h02, "R6 obf ch1");
    hostRd(2'd1, 8'hC3, "R6 data-out-SCI");
    idleChk(SRC_IRQ, 8'h00, "R10 enables clear no irq");

    // R7 input-side interrupt on ch2
    busWr(8'h3C, 8'h01);
    hostWr(2'd2, 8'h11, 1'b0);
    idleChk(SRC_IRQ, 8'h01, "R7 raise on host write");
    busRd(8'h3A, 8'h11, "R7 data-in-SCI read");
    idleChk(SRC_IRQ, 8'h00, "R7 lower on drain");

    // R8 output-side interrupt on ch2
    busWr(8'h3C, 8'h02);
    busWr(8'h32, 8'h66);
    hostRd(2'd2, 8'h66, "R8 host read");
    idleChk(SRC_IRQ, 8'h01, "R8 raise on host read");
    busWr(8'h36, 8'h67);
    idleChk(SRC_IRQ, 8'h00, "R8 lower on load");
    expect_val(SRC_OBF, 8'h04, "R8 obf ch2");

    // R10 OR of channels
    busWr(8'h2A, 8'h01);
    hostWr(2'd1, 8'h44, 1'b0);
    hostRd(2'd2, 8'h67, "R10 host read ch2");
    idleChk(SRC_IRQ, 8'h01, "R10 two sources");
    busRd(8'h22, 8'h44, "R10 drain ch1");
    idleChk(SRC_IRQ, 8'h01, "R10 ch2 still active");
    busWr(8'h32, 8'h00);
    idleChk(SRC_IRQ, 8'h00, "R10 all quiet");
    hostWr(2'd0, 8'h01, 1'b0);
    idleChk(SRC_IRQ, 8'h00, "R10 disabled side no irq");
    busRd(8'h10, 8'h01, "R10 byte still stored");

    // R11 collisions on ch2 with both enables set
    busWr(8'h3C, 8'h03);
    hostWr(2'd2, 8'hAA, 1'b0);
    @(negedge clk); quiet();
    hostChan = 2'd2; hostWrite = 1; hostWdata = 8'hBB;
    busValid = 1; busWrite = 0; busAddr = 8'h34;
    expect_val(SRC_BUS, 8'hAA, "R11 read returns old byte");
    idleChk(SRC_IBF, 8'h04, "R11 ibf stays set");
    expect_val(SRC_IRQ, 8'h01, "R11 irq raised");
    busRd(8'h34, 8'hBB, "R11 new byte kept");
    idleChk(SRC_IRQ, 8'h00, "R11 drained");
    hostRd(2'd2, 8'h00, "R11 pre-collision host read");
    @(negedge clk); quiet();
    hostChan = 2'd2; hostRead = 1;
    busValid = 1; busWrite = 1; busAddr = 8'h32; busWdata = 8'h5E;
    expect_val(SRC_HOST, 8'h00, "R11 host sees old byte");
    idleChk(SRC_OBF, 8'h04, "R11 obf set");
    expect_val(SRC_IRQ, 8'h00, "R11 irq lowered");
    hostRd(2'd2, 8'h5E, "R11 new out byte");

    idleChk(SRC_IRQ, 8'h01, "R8 final host read raise");
    @(negedge clk); quiet();
    @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule